// File: doc/BRIEF.md
# Reset Sequencer with Horizontal Startup

This block produces the internal reset of a video chip from two sources: an asynchronous active-low reset pin and a supply undervoltage flag from an analog comparator. When the pin is released, the internal reset is held a short while longer. An undervoltage condition counts only once it has lasted past a minimum width, and its reset is held much longer after the supply recovers. Each reset release leads into an initialization window, shown on a busy flag, before normal operation begins. A qualified undervoltage event at any point, including during initialization, starts the whole sequence again.

The block also drives the horizontal output. After any reset it runs free at a fixed 50 % duty cycle from an internal period counter. Once software sets the lock-enable bit, the output switches to a locked timing reference at the point where the free-running waveform would next rise, so no shortened pulse appears. Locked operation then stays in force until the next reset. All intervals are parameters in nanoseconds and are turned into clock cycles from a clock-frequency parameter. The cycle counts below are for the defaults at 200 MHz, except that the horizontal period is written generally as PER cycles with HALF = PER/2.

Top module: `rstseq_top`

## Requirements
- R1: While `rst_pin_n` is low, `sys_rst_n`, `init_busy` and `h_out` are all 0, with no need for a clock edge.
- R2: After `rst_pin_n` goes high, `sys_rst_n` stays 0 through the first 799 rising clock edges and becomes 1 after the 800th (4 us).
- R3: `init_busy` is 1 from the cycle in which `sys_rst_n` rises after a pin release, for 11200 cycles. It falls 12000 cycles after pin release (60 us in total).
- R4: `uv_flag` passes through a two-stage synchronizer. A high pulse seen on 10 or fewer consecutive rising edges (at most 50 ns) has no effect. If it is seen on 11 or more, `sys_rst_n` and `init_busy` drop after the 13th of those edges.
- R5: An undervoltage reset holds `sys_rst_n` at 0 for as long as `uv_flag` stays high. It goes on holding it until the 10002nd rising edge counted from the first edge that samples `uv_flag` low (a 10000-cycle, 50 us hold after the synchronizer).
- R6: When an undervoltage reset is released, `init_busy` is 1 for 11200 cycles, starting in the cycle in which `sys_rst_n` rises.
- R7: A qualified undervoltage event during initialization clears `init_busy` and `sys_rst_n` at once and restarts the full sequence: the hold, then a complete initialization window.
- R8: Outside locked operation, `h_out` is 1 in the cycle in which `sys_rst_n` rises. It then repeats a pattern of HALF cycles high followed by HALF cycles low, a period of PER cycles.
- R9: `lock_en` is sampled only on the last cycle of a free-running period. If it is 1 there, `h_out` equals `h_ref` delayed by one clock from the cycle in which the free-running output would have risen. The cycle before that switch always shows `h_out` low.
- R10: Once locked, `h_out` keeps following `h_ref` after `lock_en` is cleared. Any reset, from the pin or from undervoltage, returns it to free-running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_pin_n | input | 1 | External reset pin, active low, asynchronous assertion |
| uv_flag | input | 1 | Supply undervoltage comparator output, asynchronous, active high |
| lock_en | input | 1 | Software bit requesting locked horizontal operation |
| h_ref | input | 1 | Locked horizontal timing reference |
| sys_rst_n | output | 1 | Internal reset, active low |
| init_busy | output | 1 | Initialization window in progress |
| h_out | output | 1 | Horizontal drive output |

## Verification
The undervoltage qualifier is driven with pulses of 10 and 11 sampled cycles. This tells the glitch that must be ignored apart from the shortest event that must reset. Separate undervoltage events in normal operation and in mid-initialization show the difference between a plain long hold and a full restart. Pin resets applied both from power-up and during normal operation confirm the short stretch and the 60 us total. The horizontal output is exercised with a reference that toggles every three cycles while lock is requested and later withdrawn. It is then exercised with a constant-high reference across a reset, which shows whether the output is free-running or locked and where the switchover cycle falls.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

  typedef enum logic [1:0] {
    PH_PIN  = 2'd0,
    PH_UV   = 2'd1,
    PH_INIT = 2'd2,
    PH_RUN  = 2'd3
  } phase_e;

  function automatic int ns_to_cyc(input int ns, input int mhz);
    return (ns * mhz) / 1000;
  endfunction

endpackage

// File: rtl/rstseq_uv_filter.sv
module rstseq_uv_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_CYC     = 10
) (
  input  logic clk,
  input  logic arst_n,
  input  logic uv_raw,
  output logic uv_level,
  output logic uv_trip
);
  localparam int CW = $clog2(MIN_CYC + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          run_cnt;

  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sync_q[gi] <= 1'b0;
        else if (gi == 0) sync_q[gi] <= uv_raw;
        else sync_q[gi] <= sync_q[(gi == 0) ? 0 : gi-1];
      end
    end
  endgenerate

  assign uv_level = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)                          run_cnt <= '0;
    else if (!uv_level)                   run_cnt <= '0;
    else if (run_cnt != CW'(MIN_CYC))     run_cnt <= run_cnt + 1'b1;
  end

  assign uv_trip = uv_level && (run_cnt == CW'(MIN_CYC));

endmodule

// File: rtl/rstseq_fsm.sv
module rstseq_fsm
  import rstseq_pkg::*;
#(
  parameter int PIN_CYC  = 800,
  parameter int INIT_CYC = 11200,
  parameter int UVH_CYC  = 10000
) (
  input  logic   clk,
  input  logic   arst_n,
  input  logic   uv_level,
  input  logic   uv_trip,
  output phase_e phase
);
  localparam int MAXC = (PIN_CYC > INIT_CYC) ? ((PIN_CYC > UVH_CYC) ? PIN_CYC : UVH_CYC)
                                             : ((INIT_CYC > UVH_CYC) ? INIT_CYC : UVH_CYC);
  localparam int TW = $clog2(MAXC + 1);

  phase_e        ph_q;
  logic [TW-1:0] tmr_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      ph_q  <= PH_PIN;
      tmr_q <= '0;
    end else if (uv_trip) begin
      ph_q  <= PH_UV;
      tmr_q <= '0;
    end else begin
      case (ph_q)
        PH_PIN: begin
          if (tmr_q == TW'(PIN_CYC - 1)) begin
            ph_q  <= PH_INIT;
            tmr_q <= '0;
          end else tmr_q <= tmr_q + 1'b1;
        end
        PH_UV: begin
          if (uv_level) tmr_q <= '0;
          else if (tmr_q == TW'(UVH_CYC - 1)) begin
            ph_q  <= PH_INIT;
            tmr_q <= '0;
          end else tmr_q <= tmr_q + 1'b1;
        end
        PH_INIT: begin
          if (tmr_q == TW'(INIT_CYC - 1)) begin
            ph_q  <= PH_RUN;
            tmr_q <= '0;
          end else tmr_q <= tmr_q + 1'b1;
        end
        default: tmr_q <= '0;
      endcase
    end
  end

  assign phase = ph_q;

endmodule

// File: rtl/rstseq_hout.sv
module rstseq_hout #(
  parameter int PER_CYC = 12800
) (
  input  logic clk,
  input  logic arst_n,
  input  logic hold,
  input  logic lock_en,
  input  logic h_ref,
  output logic h_out,
  output logic locked
);
  localparam int HALF = PER_CYC / 2;
  localparam int CW   = $clog2(PER_CYC);

  logic [CW-1:0] ph_cnt;
  logic          lock_q;
  logic          ref_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      ph_cnt <= '0;
      lock_q <= 1'b0;
      ref_q  <= 1'b0;
    end else if (hold) begin
      ph_cnt <= '0;
      lock_q <= 1'b0;
      ref_q  <= 1'b0;
    end else begin
      ref_q <= h_ref;
      if (!lock_q) begin
        if (ph_cnt == CW'(PER_CYC - 1)) begin
          ph_cnt <= '0;
          if (lock_en) lock_q <= 1'b1;
        end else begin
          ph_cnt <= ph_cnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    if (hold)        h_out = 1'b0;
    else if (lock_q) h_out = ref_q;
    else             h_out = (ph_cnt < CW'(HALF));
  end

  assign locked = lock_q;

endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
  import rstseq_pkg::*;
#(
  parameter int CLK_MHZ        = 200,
  parameter int PIN_HOLD_NS    = 4000,
  parameter int INIT_END_NS    = 60000,
  parameter int UV_MIN_NS      = 50,
  parameter int UV_HOLD_NS     = 50000,
  parameter int HOUT_PERIOD_NS = 64000
) (
  input  logic clk,
  input  logic rst_pin_n,
  input  logic uv_flag,
  input  logic lock_en,
  input  logic h_ref,
  output logic sys_rst_n,
  output logic init_busy,
  output logic h_out
);
  localparam int PIN_CYC  = ns_to_cyc(PIN_HOLD_NS, CLK_MHZ);
  localparam int INIT_CYC = ns_to_cyc(INIT_END_NS - PIN_HOLD_NS, CLK_MHZ);
  localparam int UVM_CYC  = ns_to_cyc(UV_MIN_NS, CLK_MHZ);
  localparam int UVH_CYC  = ns_to_cyc(UV_HOLD_NS, CLK_MHZ);
  localparam int PER_CYC  = ns_to_cyc(HOUT_PERIOD_NS, CLK_MHZ);

  logic   uv_level;
  logic   uv_trip;
  phase_e phase;
  logic   hout_locked;

  rstseq_uv_filter #(.SYNC_STAGES(2), .MIN_CYC(UVM_CYC)) u_uv (
    .clk     (clk),
    .arst_n  (rst_pin_n),
    .uv_raw  (uv_flag),
    .uv_level(uv_level),
    .uv_trip (uv_trip)
  );

  rstseq_fsm #(.PIN_CYC(PIN_CYC), .INIT_CYC(INIT_CYC), .UVH_CYC(UVH_CYC)) u_fsm (
    .clk     (clk),
    .arst_n  (rst_pin_n),
    .uv_level(uv_level),
    .uv_trip (uv_trip),
    .phase   (phase)
  );

  assign sys_rst_n = (phase == PH_INIT) || (phase == PH_RUN);
  assign init_busy = (phase == PH_INIT);

  rstseq_hout #(.PER_CYC(PER_CYC)) u_hout (
    .clk    (clk),
    .arst_n (rst_pin_n),
    .hold   (!sys_rst_n),
    .lock_en(lock_en),
    .h_ref  (h_ref),
    .h_out  (h_out),
    .locked (hout_locked)
  );

endmodule

// File: rtl/rstseq_chk.sv
module rstseq_chk (
  input logic clk,
  input logic rst_pin_n,
  input logic sys_rst_n,
  input logic init_busy,
  input logic h_out,
  input logic h_ref,
  input logic hlocked
);

  AST_PIN_FORCES_RESET: assert property (@(posedge clk)
    !rst_pin_n |-> (!sys_rst_n && !init_busy && !h_out)); // R1

  AST_HOUT_QUIET_IN_RESET: assert property (@(posedge clk) disable iff (!rst_pin_n)
    !sys_rst_n |-> !h_out); // R1

  AST_RELEASE_ENTERS_INIT: assert property (@(posedge clk) disable iff (!rst_pin_n)
    $rose(sys_rst_n) |-> init_busy); // R3

  AST_FREE_RUN_STARTS_HIGH: assert property (@(posedge clk) disable iff (!rst_pin_n)
    $rose(sys_rst_n) |-> (h_out && !hlocked)); // R8

  AST_LOCK_NO_RUNT: assert property (@(posedge clk) disable iff (!rst_pin_n)
    $rose(hlocked) |-> !$past(h_out)); // R9

  AST_LOCK_FOLLOWS_REF: assert property (@(posedge clk) disable iff (!rst_pin_n)
    (hlocked && sys_rst_n) |-> (h_out == $past(h_ref))); // R9

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_pin_n)
    ($past(hlocked) && sys_rst_n && $past(sys_rst_n)) |-> hlocked); // R10

endmodule

bind rstseq_top rstseq_chk u_chk (
  .clk      (clk),
  .rst_pin_n(rst_pin_n),
  .sys_rst_n(sys_rst_n),
  .init_busy(init_busy),
  .h_out    (h_out),
  .h_ref    (h_ref),
  .hlocked  (hout_locked)
);

// File: tb/tb_rstseq_top.sv
`timescale 1ns/1ps
module tb_rstseq_top;
  localparam int PER   = 400;
  localparam int HALF  = 200;
  localparam int PINC  = 800;
  localparam int INITC = 11200;
  localparam int UVH   = 10000;

  logic clk = 1'b0;
  logic rst_pin_n = 1'b0;
  logic uv_flag = 1'b0;
  logic lock_en = 1'b0;
  logic h_ref = 1'b0;
  logic sys_rst_n, init_busy, h_out;

  int edge_n = 0;
  int n_chk  = 0;
  int n_fail = 0;

  typedef struct {
    int    at;
    int    sig;
    logic  val;
    string req;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) edge_n <= edge_n + 1;

  rstseq_top #(.HOUT_PERIOD_NS(2000)) dut (
    .clk      (clk),
    .rst_pin_n(rst_pin_n),
    .uv_flag  (uv_flag),
    .lock_en  (lock_en),
    .h_ref    (h_ref),
    .sys_rst_n(sys_rst_n),
    .init_busy(init_busy),
    .h_out    (h_out)
  );

  // driver side: queue an expected output value for a given edge count
  function automatic void expect_at(int at, int sig, logic val, string req);
    exp_t e;
    int   i;
    e.at = at; e.sig = sig; e.val = val; e.req = req;
    i = 0;
    while (i < sb.size() && sb[i].at <= at) i++;
    sb.insert(i, e);
  endfunction

  function automatic logic free_val(int n, int x);
    return ((n - x) % PER) < HALF;
  endfunction

  task automatic wait_edge(int n);
    while (edge_n < n) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // monitor side: pop and compare at the negedge the item is due
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].at <= edge_n) begin
      exp_t e;
      logic act;
      e = sb.pop_front();
      act = (e.sig == 0) ? sys_rst_n : (e.sig == 1) ? init_busy : h_out;
      n_chk++;
      if (e.at != edge_n || act !== e.val) begin
        n_fail++;
        $display("FAIL %s edge %0d (due %0d) sig %0d actual %b expected %b",
                 e.req, edge_n, e.at, e.sig, act, e.val);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired, actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    int e0, x, now, r, u, u2, d, y, v1, y1, v2, d2, y2, p;

    // R1: reset state while the pin is held
    expect_at(3, 0, 1'b0, "R1");
    expect_at(3, 1, 1'b0, "R1");
    expect_at(3, 2, 1'b0, "R1");
    wait_edge(5);

    // R2 R3 R8: pin release from power-up
    e0 = edge_n;
    rst_pin_n = 1'b1;
    x = e0 + PINC;
    expect_at(e0 + 1, 0, 1'b0, "R2");
    expect_at(x - 1, 0, 1'b0, "R2");
    expect_at(x, 0, 1'b1, "R2");
    expect_at(x, 1, 1'b1, "R3");
    expect_at(x, 2, 1'b1, "R8");
    expect_at(x + HALF - 1, 2, 1'b1, "R8");
    expect_at(x + HALF, 2, 1'b0, "R8");
    expect_at(x + PER - 1, 2, 1'b0, "R8");
    expect_at(x + PER, 2, 1'b1, "R8");
    expect_at(e0 + PINC + INITC - 1, 1, 1'b1, "R3");
    expect_at(e0 + PINC + INITC, 1, 1'b0, "R3");
    expect_at(e0 + PINC + INITC, 0, 1'b1, "R3");
    wait_edge(e0 + PINC + INITC + 2);

    // R9 R10: request lock, switch at next free-running rise, then withdraw request
    now = edge_n;
    r = x + PER * ((now - x) / PER + 1);
    lock_en = 1'b1;
    for (int n = now; n < r + 40; n++) begin
      logic pv;
      wait_edge(n);
      pv = ((n / 3) % 2) == 1;
      h_ref = pv;
      if (n == r + 10) lock_en = 1'b0;
      if (n + 1 < r) expect_at(n + 1, 2, free_val(n + 1, x), "R8");
      else if (n + 1 > r + 11) expect_at(n + 1, 2, pv, "R10");
      else expect_at(n + 1, 2, pv, "R9");
    end
    wait_edge(r + 42);

    // R4: 10-cycle glitch ignored
    h_ref = 1'b1;
    u = edge_n + 2;
    wait_edge(u);
    uv_flag = 1'b1;
    expect_at(u + 13, 0, 1'b1, "R4");
    expect_at(u + 20, 0, 1'b1, "R4");
    expect_at(u + 20, 2, 1'b1, "R4");
    wait_edge(u + 10);
    uv_flag = 1'b0;
    wait_edge(u + 30);

    // R4 R5 R6 R10: 11-cycle event resets, long hold, init window, free-run again
    u2 = edge_n;
    uv_flag = 1'b1;
    expect_at(u2 + 12, 0, 1'b1, "R4");
    expect_at(u2 + 13, 0, 1'b0, "R4");
    expect_at(u2 + 13, 2, 1'b0, "R4");
    wait_edge(u2 + 11);
    uv_flag = 1'b0;
    d = u2 + 11;
    y = d + UVH + 2;
    expect_at(d + 5000, 0, 1'b0, "R5");
    expect_at(y - 1, 0, 1'b0, "R5");
    expect_at(y, 0, 1'b1, "R5");
    expect_at(y, 1, 1'b1, "R6");
    expect_at(y, 2, 1'b1, "R10");
    expect_at(y + HALF, 2, 1'b0, "R10");
    expect_at(y + INITC - 1, 1, 1'b1, "R6");
    expect_at(y + INITC, 1, 1'b0, "R6");
    wait_edge(y + INITC + 2);

    // R7: undervoltage during initialization restarts the sequence
    v1 = edge_n;
    uv_flag = 1'b1;
    wait_edge(v1 + 25);
    uv_flag = 1'b0;
    y1 = v1 + 25 + UVH + 2;
    expect_at(y1, 1, 1'b1, "R7");
    wait_edge(y1 + 500);
    v2 = edge_n;
    uv_flag = 1'b1;
    expect_at(v2 + 12, 1, 1'b1, "R7");
    expect_at(v2 + 13, 1, 1'b0, "R7");
    expect_at(v2 + 13, 0, 1'b0, "R7");
    wait_edge(v2 + 20);
    uv_flag = 1'b0;
    d2 = v2 + 20;
    y2 = d2 + UVH + 2;
    expect_at(y2 - 1, 0, 1'b0, "R7");
    expect_at(y2, 0, 1'b1, "R7");
    expect_at(y2, 1, 1'b1, "R7");
    expect_at(y2 + INITC - 1, 1, 1'b1, "R7");
    expect_at(y2 + INITC, 1, 1'b0, "R7");
    wait_edge(y2 + INITC + 2);

    // R1 R2 R8: pin reset during normal operation
    p = edge_n;
    rst_pin_n = 1'b0;
    expect_at(p + 1, 0, 1'b0, "R1");
    expect_at(p + 1, 1, 1'b0, "R1");
    expect_at(p + 1, 2, 1'b0, "R1");
    wait_edge(p + 5);
    rst_pin_n = 1'b1;
    expect_at(p + 5 + PINC - 1, 0, 1'b0, "R2");
    expect_at(p + 5 + PINC, 0, 1'b1, "R2");
    expect_at(p + 5 + PINC, 2, 1'b1, "R8");
    wait_edge(p + 5 + PINC + 3);

    if (sb.size() != 0) begin
      n_fail++;
      $display("FAIL scoreboard R1 pending items actual %0d expected 0", sb.size());
    end
    summary();
    $finish;
  end

endmodule